// File: doc/BRIEF.md
# Cache Block Refill Burst Controller

This block serves a cache miss handler that needs a four-word block fetched from a one-word-wide, DRAM-style memory. The miss handler offers a byte address with a valid/ready handshake. The controller then puts the block-aligned address on the memory command lines for one cycle. It waits out a long row-open latency for the first word and a shorter column latency for each later word. Each word goes back to the cache on a single-cycle strobe, together with its index inside the block.

The memory behind the bus is modelled inside the block as a small register file. Its words are loaded with a fixed pattern at reset. Successive beats read successive columns of the same row, starting at the block-aligned column. A one-cycle completion pulse follows the last beat, and the controller then returns to idle. With the default latencies, one refill occupies 1 + 15 + 3×5 + 4×1 = 35 cycles of transfer activity, followed by the completion cycle.

Top module: `refill_burst_ctrl`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it is released, `busy`, `memCmdValid`, `wordValid` and `donePulse` are 0 and `reqReady` is 1.
- R2: A request is taken only at a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 1 exactly when the controller is idle. While busy, `reqValid` and `reqAddr` have no effect on any output.
- R3: In cycle 1 (the first cycle after the accepting edge), `memCmdValid` is 1 for exactly one cycle and `memCmdAddr` carries the block-aligned byte address. Outside that cycle `memCmdValid` is 0.
- R4: The first word (index 0) is strobed in cycle 17. This is 1 address cycle, then ROW_LAT = 15 wait cycles, then its return cycle.
- R5: Each later word is strobed 6 cycles after the previous one (COL_LAT = 5 wait cycles plus its return cycle), in cycles 23, 29 and 35. `wordValid` is never high in two consecutive cycles.
- R6: Words carry `wordIndex` 0, 1, 2, 3 in that order. The word at block word address b + k comes from memory entry m = (b + k) mod 64, which holds {16'hC0DE ^ m[15:0], m[15:0]}. `wordData` is 0 when `wordValid` is 0.
- R7: `donePulse` is 1 in cycle 36 only, one cycle after the fourth word. `busy` is 1 from cycle 1 through cycle 36. `reqReady` returns to 1 in cycle 37. The strobes `memCmdValid`, `wordValid` and `donePulse` are never high together.
- R8: Byte address bits [3:0] are ignored. The block word address is `reqAddr[31:2]` with its two low bits cleared.
- R9: A reset asserted in the middle of a burst ends it at once. No further words or done pulse follow, and a new request is then accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Refill request offered |
| reqAddr | input | 32 | Byte address of the missing block |
| reqReady | output | 1 | Controller idle, request can be taken |
| busy | output | 1 | Refill in progress, including the done cycle |
| memCmdValid | output | 1 | Address phase strobe on the memory bus |
| memCmdAddr | output | 32 | Block-aligned byte address during the address phase |
| wordValid | output | 1 | Returned word strobe |
| wordIndex | output | 2 | Position of the returned word in the block |
| wordData | output | 32 | Returned word |
| donePulse | output | 1 | One-cycle completion after the last word |

## Verification
The bench builds the block with its default parameters: ROW_LAT 15, COL_LAT 5, four beats and a 64-entry memory. With these values the absolute cycle of every beat (17, 23, 29, 35) and the done cycle (36) can be predicted and compared against a counting model on every clock. The small memory lets a high address wrap into entries 60 to 63 and shows that bits above the index are kept only for the command address. The short burst also leaves room to test a request that waits at the idle boundary, requests ignored while busy, and a reset in the middle of a burst, all within a few hundred cycles.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_DONE
  } rbc_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // capture request address
    logic cmdPhase;   // address phase on the memory bus
    logic xfer;       // a word is being returned this cycle
    logic advance;    // step to the next column after this beat
  } rbc_ctrl_t;

  // reset content of memory entry idx
  function automatic logic [31:0] fill_word(input int unsigned idx);
    logic [15:0] low;
    low = idx[15:0];
    return {16'hC0DE ^ low, low};
  endfunction

endpackage

// File: rtl/rbc_control.sv
module rbc_control
  import rbc_pkg::*;
#(
  parameter int ROW_LAT = 15,
  parameter int COL_LAT = 5,
  parameter int BEATS   = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      busy,
  output logic      donePulse,
  output rbc_ctrl_t ctrl
);

  localparam int MAX_LAT = (ROW_LAT > COL_LAT) ? ROW_LAT : COL_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0]  ROW_LOAD = CNT_W'(ROW_LAT - 1);
  localparam logic [CNT_W-1:0]  COL_LOAD = CNT_W'(COL_LAT - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  rbc_state_e       state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic [BEAT_W-1:0] beatCnt, beatCntNext;
  logic             accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    beatCntNext = beatCnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stateNext   = ST_ADDR;
          beatCntNext = '0;
        end
      end
      ST_ADDR: begin
        stateNext   = ST_WAIT;
        waitCntNext = ROW_LOAD;
      end
      ST_WAIT: begin
        if (waitCnt == '0) stateNext = ST_XFER;
        else               waitCntNext = waitCnt - 1'b1;
      end
      ST_XFER: begin
        if (beatCnt == LAST_BEAT) begin
          stateNext = ST_DONE;
        end else begin
          stateNext   = ST_WAIT;
          waitCntNext = COL_LOAD;
          beatCntNext = beatCnt + 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      beatCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
      beatCnt <= beatCntNext;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.loadAddr = accept;
    ctrl.cmdPhase = (state == ST_ADDR);
    ctrl.xfer     = (state == ST_XFER);
    ctrl.advance  = (state == ST_XFER);
  end

  assign reqReady  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_DONE);

  // address phase only follows an accepted request
  assert_cmd_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.cmdPhase |-> $past(reqValid && reqReady));

  // a returned word never repeats in the next cycle
  assert_single_beat_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.xfer |=> !ctrl.xfer);

  // completion follows the final beat
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.xfer && beatCnt == LAST_BEAT) |=> donePulse);

endmodule

// File: rtl/rbc_datapath.sv
module rbc_datapath
  import rbc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BEATS     = 4,
  parameter int MEM_WORDS = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  rbc_ctrl_t                 ctrl,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      memCmdValid,
  output logic [ADDR_W-1:0]         memCmdAddr,
  output logic                      wordValid,
  output logic [$clog2(BEATS)-1:0]  wordIndex,
  output logic [DATA_W-1:0]         wordData
);

  localparam int BEAT_W  = $clog2(BEATS);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int MIDX_W  = $clog2(MEM_WORDS);
  localparam int BYTE_LO = 2 + BEAT_W;

  logic [WORD_W-1:0] blockWord;
  logic [BEAT_W-1:0] beatIdx;
  logic [MIDX_W-1:0] memIndex;
  logic [DATA_W-1:0] memArray [MEM_WORDS];
  logic              unusedLowBits;

  // byte and in-block word bits are dropped by alignment
  assign unusedLowBits = ^reqAddr[BYTE_LO-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      blockWord <= '0;
      beatIdx   <= '0;
    end else begin
      if (ctrl.loadAddr) begin
        blockWord <= {reqAddr[ADDR_W-1:BYTE_LO], {BEAT_W{1'b0}}};
        beatIdx   <= '0;
      end else if (ctrl.advance) begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  // memory model: each entry loads its pattern at reset
  for (genvar i = 0; i < MEM_WORDS; i++) begin : g_mem
    always_ff @(posedge clk) begin
      if (rst) memArray[i] <= DATA_W'(fill_word(i));
    end
  end

  // sequential columns inside the open row
  assign memIndex = blockWord[MIDX_W-1:0] | MIDX_W'(beatIdx);

  assign memCmdValid = ctrl.cmdPhase;
  assign memCmdAddr  = ctrl.cmdPhase ? {blockWord, 2'b00} : '0;
  assign wordValid   = ctrl.xfer;
  assign wordIndex   = beatIdx;
  assign wordData    = ctrl.xfer ? memArray[memIndex] : '0;

  // beats leave in ascending order
  assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.advance && !ctrl.loadAddr && beatIdx != BEAT_W'(BEATS - 1))
      |=> (beatIdx == $past(beatIdx) + 1'b1));

  // the first beat of every burst is index 0
  assert_first_index_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.cmdPhase |-> (beatIdx == '0));

endmodule

// File: rtl/refill_burst_ctrl.sv
module refill_burst_ctrl
  import rbc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BEATS     = 4,
  parameter int ROW_LAT   = 15,
  parameter int COL_LAT   = 5,
  parameter int MEM_WORDS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic                     reqReady,
  output logic                     busy,
  output logic                     memCmdValid,
  output logic [ADDR_W-1:0]        memCmdAddr,
  output logic                     wordValid,
  output logic [$clog2(BEATS)-1:0] wordIndex,
  output logic [DATA_W-1:0]        wordData,
  output logic                     donePulse
);

  rbc_ctrl_t ctrl;

  rbc_control #(
    .ROW_LAT(ROW_LAT),
    .COL_LAT(COL_LAT),
    .BEATS  (BEATS)
  ) i_control (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .busy     (busy),
    .donePulse(donePulse),
    .ctrl     (ctrl)
  );

  rbc_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BEATS    (BEATS),
    .MEM_WORDS(MEM_WORDS)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .reqAddr    (reqAddr),
    .memCmdValid(memCmdValid),
    .memCmdAddr (memCmdAddr),
    .wordValid  (wordValid),
    .wordIndex  (wordIndex),
    .wordData   (wordData)
  );

  // busy starts only from an offered request
  assert_accept_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reqValid));

  // bus strobes never overlap
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memCmdValid, wordValid, donePulse}));

endmodule

// File: tb/test_refill_burst_ctrl.sv
`timescale 1ns/1ps
module test_refill_burst_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, busy, memCmdValid, wordValid, donePulse;
  logic [31:0] memCmdAddr, wordData;
  logic [1:0]  wordIndex;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  // reference model: edges since the accepting edge, 0 = idle
  int          phase = 0;
  logic [29:0] baseWord = '0;
  int          wordsSeen = 0;

  always #2 clk = ~clk;

  refill_burst_ctrl i_refill_burst_ctrl (
    .clk, .rst, .reqValid, .reqAddr, .reqReady, .busy,
    .memCmdValid, .memCmdAddr, .wordValid, .wordIndex, .wordData, .donePulse
  );

  function automatic logic [31:0] patternAt(input logic [29:0] w);
    logic [15:0] m;
    m = 16'(w % 64);
    return {16'hC0DE ^ m, m};
  endfunction

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rst) phase <= 0;
    else if (phase == 0 && reqValid) begin
      phase    <= 1;
      baseWord <= {reqAddr[31:4], 2'b00};
    end else if (phase == 36) phase <= 0;
    else if (phase > 0) phase <= phase + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cycle, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    logic expWord, expCmd, expDone;
    int   k;
    expCmd  = (phase == 1);
    expDone = (phase == 36);
    expWord = (phase >= 17 && phase <= 35 && ((phase - 17) % 6) == 0);
    k       = (phase - 17) / 6;
    check(busy == (phase > 0), rst ? "R1 busy" : "R7 busy span", 64'(busy), 64'(phase > 0));
    check(reqReady == (phase == 0), rst ? "R1 ready" : "R2 ready", 64'(reqReady), 64'(phase == 0));
    check(memCmdValid == expCmd, "R3 cmd strobe", 64'(memCmdValid), 64'(expCmd));
    if (expCmd)
      check(memCmdAddr == {baseWord, 2'b00}, "R3/R8 cmd addr", 64'(memCmdAddr), 64'({baseWord, 2'b00}));
    check(wordValid == expWord, (phase < 18) ? "R4 first word time" : "R5 word time",
          64'(wordValid), 64'(expWord));
    if (expWord) begin
      check(wordIndex == 2'(k), "R6 index", 64'(wordIndex), 64'(k));
      check(wordData == patternAt(baseWord + 30'(k)), "R6 data",
            64'(wordData), 64'(patternAt(baseWord + 30'(k))));
    end else begin
      check(wordData == '0, "R6 idle data", 64'(wordData), 64'h0);
    end
    check(donePulse == expDone, "R7 done", 64'(donePulse), 64'(expDone));
    if (wordValid) wordsSeen++;
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycle > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic burst(input logic [31:0] a);
    reqAddr  = a;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);                          // R1 idle after reset
    burst(32'h0000_0000);                    // R4 R5 R6 R7 basic
    burst(32'h0000_012F);                    // R8 low bits ignored
    burst(32'hFFFF_FFF7);                    // R6 high address wraps to entries 60..63
    // R2: requests while busy are ignored
    reqAddr = 32'h0000_0040; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 32'h0000_00A0;
    repeat (30) @(negedge clk);
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    // R2: request held across done is taken in the first idle cycle
    reqAddr = 32'h0000_0080; reqValid = 1'b1;
    repeat (37) @(negedge clk);
    reqAddr = 32'h0000_0090;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (40) @(negedge clk);
    // R9: reset mid-burst
    wordsSeen = 0;
    reqAddr = 32'h0000_0010; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(wordsSeen == 1, "R9 burst aborted", 64'(wordsSeen), 64'd1);
    burst(32'h0000_0030);                    // R9 accepted after abort
    report();
  end

endmodule